// File: doc/BRIEF.md
# General-Purpose I/O Port with Latch Readback

This block is a 16-bit general-purpose I/O port controlled through a small register interface. Each bit has four settings: a direction bit, a port view, an output latch and an open-drain enable. The pad is modelled as three separate outputs per bit: drive value, drive enable and open-drain flag. A pin input returns from the pad and is synchronised before software can read it.

Software writes the output latch through either the port address or the latch address. Reads differ by address. The port address returns the synchronised pin level. The latch address returns the stored output value. A read-modify-write through the latch address therefore never copies pin levels that are still settling back into the latch.

A peripheral can take over any pin by asserting its per-bit enable. It then supplies the drive value and drive enable, and open-drain shaping still applies on top. A parameter mask marks bits that do not exist on the port. Those bits hold no state, read as zero and never drive.

Top module: `gpio_latch_port`

## Requirements
- R1: After reset every implemented direction bit reads 1 (input). The latch and open-drain registers read 0, and no pad drive enable is asserted.
- R2: With no peripheral and open-drain off, a direction bit of 0 asserts that bit's drive enable and drives the latch value. A direction bit of 1 releases the drive enable.
- R3: Register address 0 is direction, 1 is port, 2 is latch and 3 is open-drain. A write to address 1 or 2 updates the same output latch at the next clock edge. A read of address 2 returns the latch contents whatever the pin level.
- R4: A read of address 1 returns the pin input after a two-stage synchroniser. A pin change is visible after the second rising edge following it, not after the first.
- R5: With the open-drain bit set on a driving pin, the drive value is 0 and the pad is only enabled when the data is 0. Data 1 releases the pad. The open-drain flag output mirrors the open-drain register.
- R6: Open-drain shaping applies equally when a peripheral supplies the data and drive enable.
- R7: While a peripheral enable bit is 1, the pin's drive value and drive enable come from the peripheral. Writes to the port address still update the latch, which reads back at address 2, but they do not change the pad. Address 1 still returns the pin level.
- R8: Bits cleared in the implemented mask read 0 at every address. They never assert a drive value, drive enable or open-drain flag, even after all-ones writes.
- R9: A read-modify-write of two bits through the latch address keeps both bits when the pin is slow to follow. The same sequence through the port address loses the first bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register select (0 direction, 1 port, 2 latch, 3 open-drain) |
| reg_we | input | 1 | Write strobe, sampled at the rising edge |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for the addressed register, same cycle |
| periph_en | input | 16 | Per-bit peripheral takeover enable |
| periph_dout | input | 16 | Peripheral drive values |
| periph_oe | input | 16 | Peripheral drive enables |
| pad_in | input | 16 | Pin levels returning from the pads |
| pad_out | output | 16 | Pad drive values |
| pad_oe | output | 16 | Pad drive enables |
| pad_od | output | 16 | Pad open-drain flags |

## Verification
Register writes land at the rising edge that samples the strobe. The pad outputs and the read data are combinational from the registers, so the bench checks them half a cycle after that edge. A pin change reaches address 1 only after two rising edges. The bench therefore checks the old value after one edge and the new value after the second. In the read-modify-write scenario the pin model adds three cycles of lag, so the second read falls inside the window where the first write has not yet reached the port view.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
   typedef enum logic [1:0] {
      GP_DIR = 2'd0,
      GP_PIN = 2'd1,
      GP_LAT = 2'd2,
      GP_ODE = 2'd3
   } gp_reg_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int WIDTH  = 16,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);
   logic [WIDTH-1:0] chain [STAGES];

   initial begin : elab_chk
      if (STAGES < 2) $fatal(1, "gpio_sync needs at least two stages");
   end

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) chain[0] <= '0;
            else        chain[0] <= din;
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= chain[s-1];
      end
   end

   assign dout = chain[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
   import gpio_pkg::*;
#(
   parameter int               WIDTH     = 16,
   parameter logic [WIDTH-1:0] IMPL_MASK = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       addr,
   input  logic             we,
   input  logic [WIDTH-1:0] wdata,
   input  logic [WIDTH-1:0] pin_sync,
   output logic [WIDTH-1:0] rdata,
   output logic [WIDTH-1:0] dir_q,
   output logic [WIDTH-1:0] lat_q,
   output logic [WIDTH-1:0] od_q
);
   gp_reg_e sel;
   assign sel = gp_reg_e'(addr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q <= IMPL_MASK;
         lat_q <= '0;
         od_q  <= '0;
      end else if (we) begin
         unique case (sel)
            GP_DIR:         dir_q <= wdata & IMPL_MASK;
            GP_PIN, GP_LAT: lat_q <= wdata & IMPL_MASK;
            GP_ODE:         od_q  <= wdata & IMPL_MASK;
            default: ;
         endcase
      end
   end

   always_comb begin
      unique case (sel)
         GP_DIR:  rdata = dir_q;
         GP_PIN:  rdata = pin_sync & IMPL_MASK;
         GP_LAT:  rdata = lat_q;
         GP_ODE:  rdata = od_q;
         default: rdata = '0;
      endcase
   end

   // R3: both data addresses land in the latch one edge later
   assert_latch_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (we && (addr == 2'd1 || addr == 2'd2)) |=> (lat_q == ($past(wdata) & IMPL_MASK)));

   // R8: absent bits hold no state
   assert_absent_state_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ((dir_q | lat_q | od_q) & ~IMPL_MASK) == '0);
endmodule

// File: rtl/gpio_pad_drive.sv
module gpio_pad_drive #(
   parameter int               WIDTH     = 16,
   parameter logic [WIDTH-1:0] IMPL_MASK = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] dir_q,
   input  logic [WIDTH-1:0] lat_q,
   input  logic [WIDTH-1:0] od_q,
   input  logic [WIDTH-1:0] periph_en,
   input  logic [WIDTH-1:0] periph_dout,
   input  logic [WIDTH-1:0] periph_oe,
   output logic [WIDTH-1:0] pad_out,
   output logic [WIDTH-1:0] pad_oe,
   output logic [WIDTH-1:0] pad_od
);
   logic [WIDTH-1:0] src_d, src_oe, raw_out, raw_oe;

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      always_comb begin
         src_d[i]  = periph_en[i] ? periph_dout[i] : lat_q[i];
         src_oe[i] = periph_en[i] ? periph_oe[i]   : ~dir_q[i];
         if (od_q[i]) begin
            raw_out[i] = 1'b0;
            raw_oe[i]  = src_oe[i] & ~src_d[i];
         end else begin
            raw_out[i] = src_d[i];
            raw_oe[i]  = src_oe[i];
         end
      end
   end

   assign pad_out = raw_out & IMPL_MASK;
   assign pad_oe  = raw_oe  & IMPL_MASK;
   assign pad_od  = od_q    & IMPL_MASK;

   // R5: an open-drain pad never drives high
   assert_od_low_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_od & pad_oe & pad_out) == '0);

   // R6: a peripheral '1' on an open-drain pin releases the pad
   assert_od_periph_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_od & periph_en & periph_dout & pad_oe) == '0);
endmodule

// File: rtl/gpio_latch_port.sv
module gpio_latch_port
   import gpio_pkg::*;
#(
   parameter int                WIDTH       = 16,
   parameter logic [WIDTH-1:0]  IMPL_MASK   = '1,
   parameter int                SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       reg_addr,
   input  logic             reg_we,
   input  logic [WIDTH-1:0] reg_wdata,
   output logic [WIDTH-1:0] reg_rdata,
   input  logic [WIDTH-1:0] periph_en,
   input  logic [WIDTH-1:0] periph_dout,
   input  logic [WIDTH-1:0] periph_oe,
   input  logic [WIDTH-1:0] pad_in,
   output logic [WIDTH-1:0] pad_out,
   output logic [WIDTH-1:0] pad_oe,
   output logic [WIDTH-1:0] pad_od
);
   initial begin : elab_chk
      if (WIDTH < 1 || WIDTH > 32) $fatal(1, "gpio_latch_port WIDTH out of range");
      if (SYNC_STAGES < 2)         $fatal(1, "gpio_latch_port needs two or more sync stages");
   end

   logic [WIDTH-1:0] pin_sync, dir_q, lat_q, od_q;

   gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(pad_in), .dout(pin_sync));

   gpio_regs #(.WIDTH(WIDTH), .IMPL_MASK(IMPL_MASK)) u_regs (
      .clk(clk), .rst_n(rst_n), .addr(reg_addr), .we(reg_we), .wdata(reg_wdata),
      .pin_sync(pin_sync), .rdata(reg_rdata),
      .dir_q(dir_q), .lat_q(lat_q), .od_q(od_q));

   gpio_pad_drive #(.WIDTH(WIDTH), .IMPL_MASK(IMPL_MASK)) u_drive (
      .clk(clk), .rst_n(rst_n), .dir_q(dir_q), .lat_q(lat_q), .od_q(od_q),
      .periph_en(periph_en), .periph_dout(periph_dout), .periph_oe(periph_oe),
      .pad_out(pad_out), .pad_oe(pad_oe), .pad_od(pad_od));

   // R8: absent bits never reach the pad
   assert_absent_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ((pad_out | pad_oe | pad_od) & ~IMPL_MASK) == '0);

   // R7: push-pull pins under peripheral control follow the peripheral
   assert_periph_owns_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ((periph_en & ~pad_od & IMPL_MASK) & ((pad_out ^ periph_dout) | (pad_oe ^ periph_oe))) == '0);

   // R4: port view equals the pin two edges earlier (two-stage build only)
   if (SYNC_STAGES == 2) begin : g_sync_chk
      logic [1:0] warm;
      always_ff @(posedge clk or negedge rst_n)
         if (!rst_n)         warm <= '0;
         else if (warm != 2) warm <= warm + 2'd1;
      assert_sync_delay_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (warm == 2'd2) |-> (pin_sync == $past(pad_in, 2)));
   end
endmodule

// File: tb/sim_gpio_latch_port.sv
`timescale 1ns/1ps
module sim_gpio_latch_port;
   localparam logic [15:0] M = 16'hBFFF;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  reg_addr = '0;
   logic        reg_we = 1'b0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic [15:0] periph_en = '0, periph_dout = '0, periph_oe = '0;
   logic [15:0] pad_in, pad_out, pad_oe, pad_od;
   logic [15:0] ext = '0;
   logic        lag_on = 1'b0;
   logic [15:0] pin_now;
   logic [15:0] dly [3];
   int tests = 0, fails = 0;
   bit done = 0;

   always #2 clk = ~clk;

   gpio_latch_port #(.WIDTH(16), .IMPL_MASK(M), .SYNC_STAGES(2)) u0 (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .periph_en(periph_en), .periph_dout(periph_dout), .periph_oe(periph_oe),
      .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pad_od(pad_od));

   // pin model: driven value, else pull-up when open-drain, else external source
   always_comb
      for (int i = 0; i < 16; i++)
         pin_now[i] = pad_oe[i] ? pad_out[i] : (pad_od[i] ? 1'b1 : ext[i]);

   always @(posedge clk) begin
      dly[0] <= pin_now;
      dly[1] <= dly[0];
      dly[2] <= dly[1];
   end
   assign pad_in = lag_on ? dly[2] : pin_now;

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [15:0] d);
      @(negedge clk);
      reg_addr = a; reg_we = 1'b1; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [15:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   function automatic logic [31:0] nxt(input logic [31:0] s);
      logic [31:0] t = s;
      t ^= t << 13; t ^= t >> 17; t ^= t << 5;
      return t;
   endfunction

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   endtask

   initial begin : watchdog
      #(4 * 150000);
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
   end

   initial begin : main
      logic [15:0] v, v2;
      logic [31:0] s = 32'h1234_5678;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(2'd0, v); chk("R1 dir reset", v, M);
      rd(2'd2, v); chk("R1 latch reset", v, 16'h0000);
      rd(2'd3, v); chk("R1 od reset", v, 16'h0000);
      chk("R1 pad_oe reset", pad_oe, 16'h0000);

      // R4 synchroniser latency, all pins inputs
      @(negedge clk); ext = 16'hA5C3; reg_addr = 2'd1;
      @(negedge clk); #1 chk("R4 one edge still old", reg_rdata, 16'h0000);
      @(negedge clk); #1 chk("R4 two edges new", reg_rdata, 16'hA5C3 & M);

      // R8 all-ones writes leave absent bit quiet
      wr(2'd0, 16'h0000); wr(2'd2, 16'hFFFF); wr(2'd3, 16'hFFFF);
      rd(2'd0, v); chk("R8 dir absent", v & ~M, 16'h0000);
      rd(2'd2, v); chk("R8 latch absent", v, M);
      rd(2'd3, v); chk("R8 od absent", v, M);
      chk("R8 pad quiet", (pad_out | pad_oe | pad_od) & ~M, 16'h0000);
      wr(2'd3, 16'h0000); wr(2'd0, 16'hFFFF);

      // R2/R3/R5/R6/R7/R8 sweep over pseudo-random configurations
      for (int it = 0; it < 48; it++) begin
         logic [15:0] dv, lv, ov, pe, pdv, pov, sd, so;
         logic [15:0] e_out, e_oe;
         s = nxt(s); dv = s[15:0]; lv = s[31:16];
         s = nxt(s); ov = (it % 3 == 0) ? 16'h0000 : s[15:0]; pe = (it % 4 == 1) ? 16'h0000 : s[31:16];
         s = nxt(s); pdv = s[15:0]; pov = s[31:16];
         s = nxt(s);
         @(negedge clk);
         periph_en = pe; periph_dout = pdv; periph_oe = pov; ext = s[15:0];
         wr(2'd0, dv);
         wr((it % 2 == 0) ? 2'd1 : 2'd2, lv);
         wr(2'd3, ov);
         sd = (pe & pdv) | (~pe & (lv & M));
         so = (pe & pov) | (~pe & ~(dv & M));
         e_out = sd & ~ov & M;
         e_oe  = so & ~(ov & sd) & M;
         chk("R2/R7 pad_out", pad_out, e_out);
         chk("R5/R6 pad_oe", pad_oe, e_oe);
         chk("R5 pad_od", pad_od, ov & M);
         rd(2'd0, v); chk("R8 dir read", v, dv & M);
         rd(2'd2, v); chk("R3 latch read", v, lv & M);
         rd(2'd3, v); chk("R8 od read", v, ov & M);
         @(negedge clk);
         rd(2'd1, v); chk("R4 port read", v, pin_now & M);
      end

      // R7 port writes do not move a peripheral-owned pad
      @(negedge clk);
      periph_en = 16'hFFFF; periph_dout = 16'h3C3C; periph_oe = 16'hFFFF;
      wr(2'd3, 16'h0000); wr(2'd0, 16'h0000); wr(2'd1, 16'h0000);
      v2 = pad_out;
      wr(2'd1, 16'hFFFF);
      chk("R7 pad unchanged by port write", pad_out, v2);
      chk("R7 pad follows peripheral", pad_out, 16'h3C3C & M);
      rd(2'd2, v); chk("R7 latch took write", v, M);
      @(negedge clk);
      rd(2'd1, v); chk("R7 port reads pin", v, 16'h3C3C & M);
      @(negedge clk); periph_en = 16'h0000;

      // R9 read-modify-write hazard with a slow pin
      wr(2'd0, 16'h0000); wr(2'd2, 16'h0000);
      repeat (8) @(negedge clk);
      lag_on = 1'b1;
      repeat (8) @(negedge clk);
      rd(2'd1, v);  wr(2'd1, v | 16'h0001);
      rd(2'd1, v2); wr(2'd1, v2 | 16'h0002);
      rd(2'd2, v); chk("R9 port RMW loses bit 0", v, 16'h0002);
      wr(2'd2, 16'h0000);
      repeat (8) @(negedge clk);
      rd(2'd2, v);  wr(2'd2, v | 16'h0001);
      rd(2'd2, v2); wr(2'd2, v2 | 16'h0002);
      rd(2'd2, v); chk("R9 latch RMW keeps both", v, 16'h0003);
      lag_on = 1'b0;

      repeat (2) @(negedge clk);
      finish_run();
   end
endmodule